// File: doc/BRIEF.md
# Remote DMA Byte Transfer Engine

This block is the host-facing copy channel of a packet controller. Software programs a 16-bit start address and a 16-bit byte count, then issues a 3-bit command. The engine either moves bytes from local packet memory out to the host data port (remote read, or the send-packet operation, which moves data in the same direction), or moves host-supplied data into memory (remote write). Each host strobe moves one byte or one 16-bit word, depending on a width input. For word transfers, a byte-order input chooses which half of the host word holds the byte at the lower memory address.

The current address and remaining count are output at all times. A one-cycle completion pulse marks the point where the count reaches zero. An abort command stops the transfer at once. After an abort, the current address keeps its advanced value and the remaining count stays visible, so the host can inspect it and then clear it. In read direction the engine fetches the next memory location before the host asks for it, and a ready flag tells the host when it may strobe.

Top module: `rdma_engine`

## Requirements
- R1: After reset the engine is idle (`busy`=0), `cur_addr`=0, `cur_count`=0, `done`=0, `data_ready`=0 and no memory request is made.
- R2: Command codes on `cmd_code` when `cmd_valid`=1: 3'b001 starts a remote read, 3'b011 starts a send-packet transfer (memory to host, same data path as read), 3'b010 starts a remote write, and any code with bit 2 set aborts. Code 3'b000 has no effect: the engine stays idle and no memory request is made.
- R3: In read or send direction the engine fetches memory at `cur_addr` ahead of the host strobe and raises `data_ready` once the data is held. In byte mode (`word_mode`=0) `hp_rdata` carries the byte at `cur_addr` in bits 7:0, with bits 15:8 zero.
- R4: In byte mode each host strobe increments `cur_addr` by 1 and decrements `cur_count` by 1.
- R5: In word mode (`word_mode`=1) each host strobe increments `cur_addr` by 2 and decrements `cur_count` by 2, saturating at zero. An odd count of 3 therefore ends after two strobes, with the address advanced by 4.
- R6: In word mode with `swap_bytes`=0 the byte at the lower memory address sits in host bits 7:0. With `swap_bytes`=1 it sits in bits 15:8. The same mapping applies to reads and writes.
- R7: In write direction each `hp_wr` strobe makes one memory write at `cur_addr` in the same cycle. Memory lane 0 (`mem_wdata[7:0]`) goes to `mem_addr` and lane 1 to `mem_addr+1`. `mem_be` is 2'b01 in byte mode and 2'b11 in word mode. In byte mode `mem_wdata[15:8]` is zero.
- R8: When a strobe brings the count to zero, the engine returns to idle and `done` is high for exactly the next cycle. A start command with a count of zero completes at once with the same pulse.
- R9: An abort during a transfer returns the engine to idle in the next cycle without a `done` pulse. `cur_addr` and `cur_count` keep their advanced values and are not reloaded from the start address.
- R10: Register writes (`cfg_sel`=0 start address, `cfg_sel`=1 byte count) take effect only while idle. Writing a count of zero after an abort clears `cur_count`. Register writes made while busy are ignored.
- R11: A start command issued while a transfer is active is ignored. The transfer keeps its direction, address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = start address, 1 = byte count |
| cfg_wdata | input | 16 | Register write value |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| word_mode | input | 1 | 0 = byte transfers, 1 = 16-bit word transfers |
| swap_bytes | input | 1 | Word byte order select |
| hp_rd | input | 1 | Host read strobe |
| hp_wr | input | 1 | Host write strobe |
| hp_wdata | input | 16 | Host write data |
| hp_rdata | output | 16 | Host read data |
| data_ready | output | 1 | Host may strobe in the active direction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_be | output | 2 | Memory byte-lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the request |
| cur_addr | output | 16 | Current address |
| cur_count | output | 16 | Remaining byte count |
| busy | output | 1 | Transfer active |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step size or a broken saturation shows up on `cur_addr` or `cur_count` in the cycle after the offending strobe. A mis-mapped byte lane corrupts the very next `hp_rdata` word or memory write item, which the scoreboard compares as each one appears. A faulty abort or ignore path shows up either as a `busy` or `done` value one cycle after the command, or as a stray memory request that leaves an unmatched or unexpected scoreboard entry.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_WRITE = 3'd4
    } rdma_state_e;

    localparam logic [2:0] CMD_NONE  = 3'b000;
    localparam logic [2:0] CMD_READ  = 3'b001;
    localparam logic [2:0] CMD_WRITE = 3'b010;
    localparam logic [2:0] CMD_SEND  = 3'b011;

endpackage

// File: rtl/rdma_cmd_decode.sv
module rdma_cmd_decode (
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    output logic       start_rd,
    output logic       start_wr,
    output logic       abort
);
    import rdma_pkg::*;

    always_comb begin
        start_rd = 1'b0;
        start_wr = 1'b0;
        abort    = 1'b0;
        if (cmd_valid) begin
            if (cmd_code[2]) begin
                abort = 1'b1;
            end else begin
                unique case (cmd_code)
                    CMD_READ,
                    CMD_SEND:  start_rd = 1'b1;
                    CMD_WRITE: start_wr = 1'b1;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rdma_lane_pack.sv
module rdma_lane_pack #(
    parameter int DATA_W = 16
) (
    input  logic              word_mode,
    input  logic              swap_bytes,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] host_rword
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] wide_w;
    logic [DATA_W-1:0] wide_r;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int MIRROR = LANES - 1 - i;
        assign wide_w[i*8 +: 8] = swap_bytes ? host_wdata[MIRROR*8 +: 8]
                                             : host_wdata[i*8 +: 8];
        assign wide_r[i*8 +: 8] = swap_bytes ? mem_rdata[MIRROR*8 +: 8]
                                             : mem_rdata[i*8 +: 8];
    end

    always_comb begin
        if (word_mode) begin
            mem_wdata  = wide_w;
            mem_be     = '1;
            host_rword = wide_r;
        end else begin
            mem_wdata  = {{(DATA_W-8){1'b0}}, host_wdata[7:0]};
            mem_be     = {{(LANES-1){1'b0}}, 1'b1};
            host_rword = {{(DATA_W-8){1'b0}}, mem_rdata[7:0]};
        end
    end

endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              abort,
    input  logic              word_mode,
    input  logic              hp_rd,
    input  logic              hp_wr,
    input  logic [DATA_W-1:0] rd_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              data_ready,
    output logic [DATA_W-1:0] hold_word,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              busy,
    output logic              done
);
    import rdma_pkg::*;

    localparam int WORD_STEP = DATA_W / 8;

    typedef struct packed {
        rdma_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] start;
        logic [CNT_W-1:0]  count;
        logic [DATA_W-1:0] hold;
        logic              done;
    } ctrl_s;

    ctrl_s st_d, st_q;

    logic [CNT_W-1:0]  step_c;
    logic [CNT_W-1:0]  cnt_after;
    logic [ADDR_W-1:0] addr_after;

    always_comb begin
        step_c     = word_mode ? CNT_W'(WORD_STEP) : CNT_W'(1);
        cnt_after  = (st_q.count > step_c) ? (st_q.count - step_c) : '0;
        addr_after = st_q.addr + ADDR_W'(step_c);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start_rd || start_wr) begin
                    st_d.addr = st_q.start;
                    if (st_q.count == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.state = start_wr ? ST_WRITE : ST_FETCH;
                    end
                end else if (cfg_we) begin
                    if (cfg_sel) st_d.count = cfg_wdata;
                    else         st_d.start = ADDR_W'(cfg_wdata);
                end
            end
            ST_FETCH: begin
                st_d.state = abort ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: begin
                if (abort) begin
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.hold  = rd_word;
                    st_d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (abort) begin
                    st_d.state = ST_IDLE;
                end else if (hp_rd) begin
                    st_d.addr  = addr_after;
                    st_d.count = cnt_after;
                    if (cnt_after == '0) begin
                        st_d.state = ST_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.state = ST_FETCH;
                    end
                end
            end
            ST_WRITE: begin
                if (abort) begin
                    st_d.state = ST_IDLE;
                end else if (hp_wr) begin
                    st_d.addr  = addr_after;
                    st_d.count = cnt_after;
                    if (cnt_after == '0) begin
                        st_d.state = ST_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, addr: '0, start: '0, count: '0,
                      hold: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_req    = !abort && ((st_q.state == ST_FETCH) ||
                                (st_q.state == ST_WRITE && hp_wr));
        mem_we     = (st_q.state == ST_WRITE);
        mem_addr   = st_q.addr;
        data_ready = (st_q.state == ST_HOLD) || (st_q.state == ST_WRITE);
        hold_word  = st_q.hold;
        cur_addr   = st_q.addr;
        cur_count  = st_q.count;
        busy       = (st_q.state != ST_IDLE);
        done       = st_q.done;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R8
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.count == '0 && st_q.state == ST_IDLE)); // R8
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (st_q.state == ST_IDLE && !st_q.done)); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && st_q.addr != $past(st_q.addr)) |->
        ((st_q.addr - $past(st_q.addr)) == ADDR_W'(1) ||
         (st_q.addr - $past(st_q.addr)) == ADDR_W'(WORD_STEP))); // R4
    AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && st_q.count != $past(st_q.count)) |->
        (st_q.count < $past(st_q.count))); // R5
    AST_BUSY_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_WRITE && !abort) |=>
        (st_q.state == ST_WRITE || st_q.state == ST_IDLE)); // R11

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [CNT_W-1:0]    cfg_wdata,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_code,
    input  logic                word_mode,
    input  logic                swap_bytes,
    input  logic                hp_rd,
    input  logic                hp_wr,
    input  logic [DATA_W-1:0]   hp_wdata,
    output logic [DATA_W-1:0]   hp_rdata,
    output logic                data_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [CNT_W-1:0]    cur_count,
    output logic                busy,
    output logic                done
);
    logic              start_rd_w;
    logic              start_wr_w;
    logic              abort_w;
    logic [DATA_W-1:0] rd_word_w;

    rdma_cmd_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .start_rd  (start_rd_w),
        .start_wr  (start_wr_w),
        .abort     (abort_w)
    );

    rdma_lane_pack #(.DATA_W(DATA_W)) u_pack (
        .word_mode  (word_mode),
        .swap_bytes (swap_bytes),
        .host_wdata (hp_wdata),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be),
        .host_rword (rd_word_w)
    );

    rdma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .start_rd   (start_rd_w),
        .start_wr   (start_wr_w),
        .abort      (abort_w),
        .word_mode  (word_mode),
        .hp_rd      (hp_rd),
        .hp_wr      (hp_wr),
        .rd_word    (rd_word_w),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .data_ready (data_ready),
        .hold_word  (hp_rdata),
        .cur_addr   (cur_addr),
        .cur_count  (cur_count),
        .busy       (busy),
        .done       (done)
    );

    AST_ILLEGAL_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_code == 3'b000) |=> (!busy && !done)); // R2
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> !mem_req); // R1

endmodule

// File: tb/rdma_engine_bench.sv
module rdma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = '0;
    logic        word_mode = 1'b0;
    logic        swap_bytes = 1'b0;
    logic        hp_rd = 1'b0;
    logic        hp_wr = 1'b0;
    logic [15:0] hp_wdata = '0;
    logic [15:0] hp_rdata;
    logic        data_ready;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] cur_addr;
    logic [15:0] cur_count;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  mem [256];
    logic [15:0] rd_q [$];
    logic [33:0] wr_q [$];

    always #4 clk = ~clk;

    rdma_engine u_rdma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .word_mode(word_mode), .swap_bytes(swap_bytes), .hp_rd(hp_rd),
        .hp_wr(hp_wr), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
        .data_ready(data_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cur_addr(cur_addr), .cur_count(cur_count),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] init_byte(int a);
        return 8'(a * 7 + 8'h5A);
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_byte(i);
    end

    always @(posedge clk) begin
        if (mem_req && !mem_we) begin
            mem_rdata <= {mem[8'(mem_addr + 16'd1)], mem[mem_addr[7:0]]};
        end
        if (mem_req && mem_we) begin
            if (mem_be[0]) mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_be[1]) mem[8'(mem_addr + 16'd1)] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares scoreboard items as the design produces them
    always @(negedge clk) begin
        #1;
        if (rst_n && hp_rd && data_ready) begin
            if (rd_q.size() == 0) chk(1'b0, "R3 unexpected read", 32'(hp_rdata), 0);
            else begin
                logic [15:0] e;
                e = rd_q.pop_front();
                chk(hp_rdata == e, "R3/R6 read data", 32'(hp_rdata), 32'(e));
            end
        end
        if (rst_n && mem_req && mem_we) begin
            if (wr_q.size() == 0) chk(1'b0, "R7 unexpected write", 32'(mem_addr), 0);
            else begin
                logic [33:0] e;
                e = wr_q.pop_front();
                chk({mem_addr, mem_be, mem_wdata} == e, "R7/R6 write item",
                    32'({mem_addr, mem_wdata}), 32'({e[33:18], e[15:0]}));
            end
        end
    end

    task automatic cfg(input bit sel, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic host_read(input logic [15:0] exp);
        while (!data_ready) @(negedge clk);
        hp_rd = 1'b1;
        rd_q.push_back(exp);
        @(negedge clk);
        hp_rd = 1'b0;
    endtask

    task automatic host_write(input logic [15:0] v, input logic [33:0] exp);
        while (!data_ready) @(negedge clk);
        hp_wr = 1'b1; hp_wdata = v;
        wr_q.push_back(exp);
        @(negedge clk);
        hp_wr = 1'b0;
    endtask

    function automatic logic [15:0] wexp(int a, bit sw);
        return sw ? {mem[8'(a)], mem[8'(a + 1)]} : {mem[8'(a + 1)], mem[8'(a)]};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && cur_addr == 0 && cur_count == 0 && !done && !data_ready && !mem_req,
            "R1 reset", 32'({busy, done, cur_count}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 code 000 ignored
        cfg(1'b0, 16'h0010); cfg(1'b1, 16'd3);
        cmd(3'b000);
        chk(!busy && !mem_req && cur_addr == 0, "R2 code 000 ignored", 32'(busy), 0);
        @(negedge clk);
        chk(!busy && !done, "R2 code 000 stays idle", 32'(busy), 0);

        // R3/R4 byte read
        word_mode = 1'b0;
        cmd(3'b001);
        for (int i = 0; i < 3; i++) begin
            host_read({8'h00, mem[8'(16 + i)]});
            if (i == 0) chk(cur_addr == 16'h11 && cur_count == 2, "R4 byte step",
                            32'({cur_addr, cur_count}), 32'h0011_0002);
        end
        chk(done && !busy, "R8 done pulse", 32'({done, busy}), 32'b10);
        chk(cur_addr == 16'h13 && cur_count == 0, "R4 byte end", 32'(cur_addr), 32'h13);
        @(negedge clk);
        chk(!done, "R8 done single cycle", 32'(done), 0);

        // R6 word read, low half first
        word_mode = 1'b1; swap_bytes = 1'b0;
        cfg(1'b0, 16'h0020); cfg(1'b1, 16'd4);
        cmd(3'b001);
        host_read(wexp(16'h20, 1'b0));
        host_read(wexp(16'h22, 1'b0));
        chk(cur_addr == 16'h24 && done, "R5 word step", 32'(cur_addr), 32'h24);

        // R5/R6 odd count word read with swapped order
        swap_bytes = 1'b1;
        cfg(1'b0, 16'h0030); cfg(1'b1, 16'd3);
        cmd(3'b001);
        host_read(wexp(16'h30, 1'b1));
        chk(cur_count == 1 && busy, "R5 odd count after one word", 32'(cur_count), 1);
        host_read(wexp(16'h32, 1'b1));
        chk(cur_count == 0 && cur_addr == 16'h34 && done, "R5 saturate",
            32'({cur_addr, cur_count}), 32'h0034_0000);

        // R2 send packet behaves as memory-to-host
        word_mode = 1'b0; swap_bytes = 1'b0;
        cfg(1'b0, 16'h0038); cfg(1'b1, 16'd2);
        cmd(3'b011);
        host_read({8'h00, mem[8'h38]});
        host_read({8'h00, mem[8'h39]});
        chk(done && cur_addr == 16'h3A, "R2 send packet", 32'(cur_addr), 32'h3A);

        // R7 byte writes
        cfg(1'b0, 16'h0040); cfg(1'b1, 16'd2);
        cmd(3'b010);
        host_write(16'h77AB, {16'h0040, 2'b01, 16'h00AB});
        host_write(16'h00CD, {16'h0041, 2'b01, 16'h00CD});
        chk(done && mem[8'h40] == 8'hAB && mem[8'h41] == 8'hCD, "R7 byte write",
            32'({mem[8'h40], mem[8'h41]}), 32'hABCD);

        // R6/R7 word write swapped
        word_mode = 1'b1; swap_bytes = 1'b1;
        cfg(1'b0, 16'h0050); cfg(1'b1, 16'd2);
        cmd(3'b010);
        host_write(16'h1234, {16'h0050, 2'b11, 16'h3412});
        chk(mem[8'h50] == 8'h12 && mem[8'h51] == 8'h34, "R6 swapped write",
            32'({mem[8'h50], mem[8'h51]}), 32'h1234);

        // R9 abort mid-transfer
        word_mode = 1'b0; swap_bytes = 1'b0;
        cfg(1'b0, 16'h0060); cfg(1'b1, 16'd10);
        cmd(3'b001);
        for (int i = 0; i < 3; i++) host_read({8'h00, mem[8'(16'h60 + i)]});
        cmd(3'b100);
        chk(!busy && !done, "R9 abort stops", 32'({busy, done}), 0);
        chk(cur_addr == 16'h63 && cur_count == 7, "R9 address kept",
            32'({cur_addr, cur_count}), 32'h0063_0007);
        @(negedge clk);
        chk(!done && !data_ready, "R9 no done after abort", 32'(done), 0);

        // R10 count cleared after abort
        cfg(1'b1, 16'd0);
        chk(cur_count == 0 && cur_addr == 16'h63, "R10 clear count", 32'(cur_count), 0);

        // R8 zero-count start completes at once
        cmd(3'b001);
        chk(done && !busy && cur_addr == 16'h60, "R8 zero count", 32'({done, cur_addr}),
            32'h1_0060);

        // R11/R10 commands and register writes ignored while busy
        cfg(1'b0, 16'h0070); cfg(1'b1, 16'd4);
        cmd(3'b010);
        cmd(3'b001);
        cfg(1'b1, 16'h0099);
        chk(busy && cur_count == 4 && data_ready, "R11 busy cmd ignored",
            32'(cur_count), 4);
        for (int i = 0; i < 4; i++)
            host_write(16'(16'hE0 + i), {16'(16'h70 + i), 2'b01, 16'(16'hE0 + i)});
        chk(done && cur_addr == 16'h74, "R11 write finished", 32'(cur_addr), 32'h74);
        chk(mem[8'h73] == 8'hE3, "R10 busy cfg ignored", 32'(mem[8'h73]), 32'hE3);

        // R9 abort when idle has no effect
        cmd(3'b111);
        chk(!busy && cur_addr == 16'h74 && !done, "R9 idle abort", 32'(cur_addr), 32'h74);

        repeat (3) @(negedge clk);
        chk(rd_q.size() == 0 && wr_q.size() == 0, "R3/R7 scoreboard drained",
            32'(rd_q.size() + wr_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule